// File: doc/BRIEF.md
# Transmit Descriptor Walker with Gather

This block walks one transmit descriptor of sixteen 64-bit words held in a local descriptor memory. A one-cycle `start` pulse gives it the word address of the descriptor. The block reads and decodes the command header. It then sends the frame as a byte stream over a valid/ready interface. The bytes come first from the inline payload inside the descriptor and then from up to three gather buffers in a second, word-addressed buffer memory. Both memories have one read port with a read latency of one cycle.

When the frame ends, the block writes a completion status word over the header word of the same descriptor. If the header asked for it, the block then raises a one-cycle interrupt request. While the stream runs, an abort-cause input can record failure flags. If the header's termination bit is set, an abort also cuts the stream short.

Back-pressure rules: a byte is transferred in a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the block holds `out_data` and `out_last` stable. The only exception is a terminating abort, which withdraws `out_valid` in the next cycle. `out_ready` may change freely at any time.

Top module: `tx_desc_walker`

## Requirements
- R1: After reset, `out_valid`, `irq`, `busy`, `desc_rd_en`, `desc_wr_en` and `buf_rd_en` are all low.
- R2: Header fields: bits 15:0 hold the inline length minus one, bits 22:16 hold a byte offset, bit 23 is the terminate-on-abort request, bit 24 is the interrupt request, and bits 27:25 are the valid flags of gather pointers 1..3. The inline bytes start at descriptor byte 8 + offset. Exactly length-minus-one + 1 of them are sent, taken little-endian from each word (byte k of a word is bits 8k+7:8k). Reads and the write-back are never issued in the same cycle.
- R3: Gather pointer k sits in descriptor word k. Its bits 31:3 are the buffer's 8-byte word address and its bits 47:32 are the byte count minus one. Valid gather buffers follow the inline bytes in index order 1, 2, 3, and any buffer whose flag is clear is skipped.
- R4: Once `out_valid` is high with `out_ready` low, `out_valid`, `out_data` and `out_last` hold until the transfer, unless a terminating abort occurs.
- R5: `out_last` is high exactly on the final byte of a frame that completes normally.
- R6: The status word is written to the header address once, after the last byte has been accepted. Its fields are: bit 63 = 1, bits 62:29 = 0, bits 22:20 = 0, bit 23 = success, bits 19:16 = `coll_count`, and bits 15:0 = the number of bytes accepted.
- R7: An abort-cause bit i seen while streaming sets status bit 24+i and clears bit 23. Bit i maps as follows: 0 too long, 1 underrun, 2 excess collisions, 3 excess deferrals, 4 late collision. Without the termination request the whole frame is still sent.
- R8: With the termination request set, an abort ends the stream. A transfer in the same cycle as the abort is counted. No further byte is offered, and the write-back follows.
- R9: `irq` pulses for one cycle, in the cycle right after the write-back, and only if header bit 24 was set.
- R10: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin walking the descriptor at `desc_base` |
| desc_base | input | DESC_AW | Word address of the descriptor header |
| busy | output | 1 | A descriptor is in progress |
| desc_rd_en | output | 1 | Descriptor memory read strobe |
| desc_wr_en | output | 1 | Descriptor memory write strobe (status write-back) |
| desc_addr | output | DESC_AW | Descriptor memory word address |
| desc_wdata | output | 64 | Completion status word |
| desc_rdata | input | 64 | Descriptor read data, one cycle after the strobe |
| buf_rd_en | output | 1 | Gather buffer memory read strobe |
| buf_addr | output | 29 | Gather buffer word address |
| buf_rdata | input | 64 | Buffer read data, one cycle after the strobe |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the frame |
| abort_in | input | 5 | Abort causes, sampled while streaming |
| coll_count | input | 4 | Collision retry count placed in the status |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The critical coincidence is a terminating abort that lands in the same cycle as a byte transfer. The bench provokes it by raising the abort cause while `out_ready` is held high, so a transfer is almost certainly under way in that cycle. It judges the result by comparing the byte count that the monitor saw against the length field of the written status. It also confirms that no byte arrives afterwards and that the too-long flag is set. A second coincidence is a `start` pulse that arrives in the middle of a gathered frame. The bench checks that it leaves exactly one write-back, at the original header address.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int WORD_W   = 64;
  localparam int BYTE_W   = 8;
  localparam int NUM_CAT  = 3;
  localparam int NUM_ABRT = 5;
  localparam int LEN_W    = 16;
  localparam int OFF_W    = 7;
  localparam int BADDR_W  = 29;
  localparam int LANES    = WORD_W / BYTE_W;
  localparam int LANE_IW  = $clog2(LANES);
  localparam int FLAG_W   = 9;
  localparam int COLL_W   = 4;

  typedef struct packed {
    logic [NUM_CAT-1:0] cat_vld;
    logic               irq_req;
    logic               term_req;
    logic [OFF_W-1:0]   offset;
    logic [LEN_W-1:0]   len_m1;
  } hdr_t;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR_RD, S_HDR_LAT, S_PTR_RD, S_PTR_LAT,
    S_WRD_RD, S_WRD_LAT, S_EMIT, S_WB, S_IRQ
  } st_t;

  // Lowest-numbered valid gather index above cur; 0 means none remain.
  function automatic logic [1:0] next_seg(input logic [NUM_CAT-1:0] vld,
                                          input logic [1:0] cur);
    logic [1:0] r;
    r = '0;
    for (int k = NUM_CAT; k >= 1; k--) begin
      if (vld[k-1] && (k > int'(cur))) r = 2'(k);
    end
    return r;
  endfunction
endpackage

// File: rtl/txw_hdr_decode.sv
module txw_hdr_decode
  import txw_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output hdr_t              hdr_o
);
  // Reserved bits 63:28 carry no function.
  wire [35:0] unused_rsvd = word_i[63:28];

  always_comb begin
    hdr_o.len_m1   = word_i[15:0];
    hdr_o.offset   = word_i[22:16];
    hdr_o.term_req = word_i[23];
    hdr_o.irq_req  = word_i[24];
    hdr_o.cat_vld  = word_i[27:25];
  end
endmodule

// File: rtl/txw_byte_pick.sv
module txw_byte_pick
  import txw_pkg::*;
(
  input  logic [WORD_W-1:0]  word_i,
  input  logic [LANE_IW-1:0] idx_i,
  output logic [BYTE_W-1:0]  byte_o
);
  logic [BYTE_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[BYTE_W*g +: BYTE_W];
  end

  assign byte_o = lane[idx_i];
endmodule

// File: rtl/txw_status_pack.sv
module txw_status_pack
  import txw_pkg::*;
(
  input  logic [NUM_ABRT-1:0] abort_i,
  input  logic [COLL_W-1:0]   coll_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic [WORD_W-1:0]   status_o
);
  logic [FLAG_W-1:0] flags;

  always_comb begin
    flags    = {abort_i, ~|abort_i, 3'b000};
    status_o = {1'b1, 34'b0, flags, coll_i, len_i};
  end
endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
  import txw_pkg::*;
#(
  parameter int DESC_AW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [DESC_AW-1:0]    desc_base,
  output logic                  busy,
  output logic                  desc_rd_en,
  output logic                  desc_wr_en,
  output logic [DESC_AW-1:0]    desc_addr,
  output logic [WORD_W-1:0]     desc_wdata,
  input  logic [WORD_W-1:0]     desc_rdata,
  output logic                  buf_rd_en,
  output logic [BADDR_W-1:0]    buf_addr,
  input  logic [WORD_W-1:0]     buf_rdata,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [BYTE_W-1:0]     out_data,
  output logic                  out_last,
  input  logic [NUM_ABRT-1:0]   abort_in,
  input  logic [COLL_W-1:0]     coll_count,
  output logic                  irq
);
  localparam int CUR_W = BADDR_W + LANE_IW;
  localparam int REM_W = LEN_W + 1;

  st_t                 st;
  hdr_t                hdr, hdr_d;
  logic [DESC_AW-1:0]  base;
  logic [1:0]          seg, nseg;
  logic [CUR_W-1:0]    cur;
  logic [REM_W-1:0]    remain;
  logic [LEN_W-1:0]    sent;
  logic [WORD_W-1:0]   word;
  logic [NUM_ABRT-1:0] abort_q;
  logic                streaming, kill, hs;

  txw_hdr_decode u_dec (.word_i(desc_rdata), .hdr_o(hdr_d));

  txw_byte_pick u_pick (.word_i(word), .idx_i(cur[LANE_IW-1:0]), .byte_o(out_data));

  txw_status_pack u_stat (
    .abort_i(abort_q), .coll_i(coll_count), .len_i(sent), .status_o(desc_wdata)
  );

  always_comb begin
    streaming = (st == S_PTR_RD) || (st == S_PTR_LAT) || (st == S_WRD_RD) ||
                (st == S_WRD_LAT) || (st == S_EMIT);
    kill      = streaming && hdr.term_req && (|abort_in);
    out_valid = (st == S_EMIT);
    hs        = out_valid && out_ready;
    nseg      = next_seg(hdr.cat_vld, seg);
    out_last  = out_valid && (remain == REM_W'(1)) && (nseg == 2'd0);
    busy      = (st != S_IDLE);
    irq       = (st == S_IRQ);
  end

  // Memory port sequencing: one access per cycle on either memory.
  always_comb begin
    desc_rd_en = 1'b0;
    desc_wr_en = 1'b0;
    buf_rd_en  = 1'b0;
    desc_addr  = base;
    buf_addr   = cur[CUR_W-1:LANE_IW];
    case (st)
      S_HDR_RD: desc_rd_en = 1'b1;
      S_PTR_RD: begin
        desc_rd_en = 1'b1;
        desc_addr  = base + DESC_AW'(seg);
      end
      S_WRD_RD: begin
        if (seg == 2'd0) begin
          desc_rd_en = 1'b1;
          desc_addr  = base + DESC_AW'(cur[7:LANE_IW]);
        end else begin
          buf_rd_en = 1'b1;
        end
      end
      S_WB:    desc_wr_en = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      hdr     <= '0;
      base    <= '0;
      seg     <= '0;
      cur     <= '0;
      remain  <= '0;
      sent    <= '0;
      word    <= '0;
      abort_q <= '0;
    end else begin
      if (streaming) abort_q <= abort_q | abort_in;
      if (hs) begin
        sent   <= sent + LEN_W'(1);
        cur    <= cur + CUR_W'(1);
        remain <= remain - REM_W'(1);
      end
      case (st)
        S_IDLE: begin
          if (start) begin
            base    <= desc_base;
            abort_q <= '0;
            sent    <= '0;
            seg     <= '0;
            st      <= S_HDR_RD;
          end
        end
        S_HDR_RD: st <= S_HDR_LAT;
        S_HDR_LAT: begin
          hdr    <= hdr_d;
          cur    <= CUR_W'(LANES) + CUR_W'(hdr_d.offset);
          remain <= REM_W'(hdr_d.len_m1) + REM_W'(1);
          seg    <= '0;
          st     <= S_WRD_RD;
        end
        S_PTR_RD: st <= S_PTR_LAT;
        S_PTR_LAT: begin
          cur    <= {desc_rdata[31:3], 3'b000};
          remain <= REM_W'(desc_rdata[47:32]) + REM_W'(1);
          st     <= S_WRD_RD;
        end
        S_WRD_RD: st <= S_WRD_LAT;
        S_WRD_LAT: begin
          word <= (seg == 2'd0) ? desc_rdata : buf_rdata;
          st   <= S_EMIT;
        end
        S_EMIT: begin
          if (hs) begin
            if (remain == REM_W'(1)) begin
              if (nseg == 2'd0) begin
                st <= S_WB;
              end else begin
                seg <= nseg;
                st  <= S_PTR_RD;
              end
            end else if (cur[LANE_IW-1:0] == LANE_IW'(LANES - 1)) begin
              st <= S_WRD_RD;
            end
          end
        end
        S_WB:    st <= hdr.irq_req ? S_IRQ : S_IDLE;
        S_IRQ:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (kill) st <= S_WB;
    end
  end

  // ---------------- assertions ----------------
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !out_valid && !irq && !desc_wr_en);

  p_one_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_wr_en && (desc_rd_en || buf_rd_en)) && !(desc_rd_en && buf_rd_en));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !kill) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_wb_format_r6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> (desc_wdata[63] && (desc_wdata[62:29] == '0) && (desc_wdata[22:20] == '0)));

  p_wb_no_stream_r6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> !out_valid);

  p_success_r7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> (desc_wdata[23] == (desc_wdata[28:24] == '0)));

  p_kill_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!out_valid && desc_wr_en));

  p_irq_after_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(desc_wr_en));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(base));
endmodule

// File: tb/tx_desc_walker_tb.sv
module tx_desc_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  desc_base = '0;
  logic        busy, desc_rd_en, desc_wr_en, buf_rd_en;
  logic [7:0]  desc_addr;
  logic [63:0] desc_wdata, desc_rdata, buf_rdata;
  logic [28:0] buf_addr;
  logic        out_valid, out_ready, out_last, irq;
  logic [7:0]  out_data;
  logic [4:0]  abort_in = '0;
  logic [3:0]  coll_count = 4'd3;

  always #2.5 clk = ~clk;

  tx_desc_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_base(desc_base), .busy(busy),
    .desc_rd_en(desc_rd_en), .desc_wr_en(desc_wr_en), .desc_addr(desc_addr),
    .desc_wdata(desc_wdata), .desc_rdata(desc_rdata), .buf_rd_en(buf_rd_en),
    .buf_addr(buf_addr), .buf_rdata(buf_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .abort_in(abort_in), .coll_count(coll_count), .irq(irq)
  );

  int n_chk = 0, n_err = 0;
  int wb_cnt = 0, irq_cnt = 0, rx_cnt = 0;
  logic [63:0] wb_data;
  logic [7:0]  wb_addr;
  logic [63:0] dmem [0:255];
  logic [63:0] bmem [0:255];
  logic [8:0]  exp_q [$];
  bit          rdy_mode = 1'b0;
  bit          term_active = 1'b0;
  bit          done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  // Memory models, one-cycle read latency.
  always @(posedge clk) begin
    if (desc_rd_en) desc_rdata <= dmem[desc_addr];
    if (buf_rd_en)  buf_rdata  <= bmem[buf_addr[7:0]];
    if (desc_wr_en) begin
      dmem[desc_addr] <= desc_wdata;
      wb_data <= desc_wdata;
      wb_addr <= desc_addr;
      wb_cnt  <= wb_cnt + 1;
    end
  end

  // Ready driver, changes just after the edge.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rdy_mode ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  // Scoreboard monitor.
  bit          hold_prev = 1'b0, wr_prev = 1'b0;
  logic [8:0]  prev_out;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev)
        chk(out_valid && ({out_last, out_data} == prev_out), "R4 held byte",
            {55'b0, out_last, out_data}, {55'b0, prev_out});
      hold_prev = out_valid && !out_ready && !(term_active && abort_in != 0);
      prev_out  = {out_last, out_data};
      if (out_valid && out_ready) begin
        rx_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected byte", {56'b0, out_data}, 64'b0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({out_last, out_data} == e, "R2/R3/R5 byte and last",
              {55'b0, out_last, out_data}, {55'b0, e});
        end
      end
      if (irq) begin
        irq_cnt++;
        chk(wr_prev, "R9 irq right after write-back", {63'b0, wr_prev}, 64'd1);
      end
      wr_prev = desc_wr_en;
    end
  end

  function automatic logic [63:0] mk_hdr(input int lenm1, input int off, input bit term,
                                         input bit irqr, input logic [2:0] vld);
    return {36'b0, vld, irqr, term, 7'(off), 16'(lenm1)};
  endfunction

  function automatic logic [63:0] mk_ptr(input int waddr, input int lenm1);
    return {16'b0, 16'(lenm1), 29'(waddr), 3'b000};
  endfunction

  function automatic logic [63:0] mk_stat(input logic [4:0] ab, input int len);
    return {1'b1, 34'b0, ab, (ab == 0), 3'b000, 4'd3, 16'(len)};
  endfunction

  task automatic push_inline(input int base, input int off, input int lenm1, input bit fin);
    for (int i = 0; i <= lenm1; i++) begin
      int a;
      logic [63:0] w;
      a = base * 8 + 8 + off + i;
      w = dmem[a >> 3];
      exp_q.push_back({fin && (i == lenm1), w[(a % 8) * 8 +: 8]});
    end
  endtask

  task automatic push_gather(input int waddr, input int lenm1, input bit fin);
    for (int i = 0; i <= lenm1; i++) begin
      int a;
      logic [63:0] w;
      a = waddr * 8 + i;
      w = bmem[(a >> 3) % 256];
      exp_q.push_back({fin && (i == lenm1), w[(a % 8) * 8 +: 8]});
    end
  endtask

  task automatic kick(input int base);
    @(posedge clk); #1;
    start = 1'b1; desc_base = 8'(base);
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_wb(input int n0);
    int t = 0;
    while (wb_cnt == n0 && t < 4000) begin
      @(posedge clk); #1; t++;
    end
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 64'b0, 64'b1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int w0, i0, r0;
    for (int i = 0; i < 256; i++) begin
      for (int b = 0; b < 8; b++) begin
        dmem[i][8*b +: 8] = 8'((i * 8 + b) ^ 8'h5A);
        bmem[i][8*b +: 8] = 8'((i * 8 + b) * 3 ^ 8'hC3);
      end
    end
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!out_valid && !busy, "R1 valid/busy low in reset", {62'b0, out_valid, busy}, 64'b0);
    chk(!irq && !desc_wr_en, "R1 irq/write low in reset", {62'b0, irq, desc_wr_en}, 64'b0);
    chk(!desc_rd_en && !buf_rd_en, "R1 read strobes low in reset", {62'b0, desc_rd_en, buf_rd_en}, 64'b0);
    rst_n = 1'b1;

    // T2: inline only, offset 0, 6 bytes, interrupt requested (R2 R5 R6 R9)
    dmem[0] = mk_hdr(5, 0, 1'b0, 1'b1, 3'b000);
    push_inline(0, 0, 5, 1'b1);
    w0 = wb_cnt; i0 = irq_cnt;
    kick(0);
    wait_wb(w0);
    chk(wb_cnt == w0 + 1, "R6 single write-back", 64'(wb_cnt - w0), 64'd1);
    chk(wb_addr == 8'd0, "R6 write-back address", {56'b0, wb_addr}, 64'd0);
    chk(wb_data == mk_stat(5'b0, 6), "R6 status word inline", wb_data, mk_stat(5'b0, 6));
    chk(irq_cnt == i0 + 1, "R9 one irq pulse", 64'(irq_cnt - i0), 64'd1);
    chk(exp_q.size() == 0, "R2 all inline bytes sent", 64'(exp_q.size()), 64'd0);

    // T3: inline + gather 1 and 3 (2 skipped), back-pressure, mid-frame start (R3 R4 R10)
    dmem[16] = mk_hdr(9, 24, 1'b0, 1'b0, 3'b101);
    dmem[17] = mk_ptr(8, 10);
    dmem[19] = mk_ptr(32, 2);
    push_inline(16, 24, 9, 1'b0);
    push_gather(8, 10, 1'b0);
    push_gather(32, 2, 1'b1);
    rdy_mode = 1'b1;
    w0 = wb_cnt; i0 = irq_cnt; r0 = rx_cnt;
    kick(16);
    do begin @(posedge clk); end while (rx_cnt - r0 < 12);
    kick(0);
    wait_wb(w0);
    chk(wb_cnt == w0 + 1, "R10 start while busy gave no second frame", 64'(wb_cnt - w0), 64'd1);
    chk(wb_addr == 8'd16, "R10 write-back at original header", {56'b0, wb_addr}, 64'd16);
    chk(wb_data == mk_stat(5'b0, 24), "R3 status length with gather", wb_data, mk_stat(5'b0, 24));
    chk(irq_cnt == i0, "R9 no irq without request", 64'(irq_cnt - i0), 64'd0);
    chk(exp_q.size() == 0, "R3 all gather bytes sent", 64'(exp_q.size()), 64'd0);
    chk(rx_cnt - r0 == 24, "R3 byte count", 64'(rx_cnt - r0), 64'd24);
    rdy_mode = 1'b0;

    // T4: abort without termination, full frame still sent (R7)
    dmem[32] = mk_hdr(19, 0, 1'b0, 1'b1, 3'b000);
    push_inline(32, 0, 19, 1'b1);
    w0 = wb_cnt; r0 = rx_cnt;
    kick(32);
    do begin @(posedge clk); end while (rx_cnt - r0 < 5);
    #1 abort_in = 5'b00100;
    @(posedge clk); #1 abort_in = 5'b0;
    wait_wb(w0);
    chk(rx_cnt - r0 == 20, "R7 frame completes despite abort", 64'(rx_cnt - r0), 64'd20);
    chk(wb_data == mk_stat(5'b00100, 20), "R7 excess-collision flag", wb_data, mk_stat(5'b00100, 20));
    chk(exp_q.size() == 0, "R7 no bytes lost", 64'(exp_q.size()), 64'd0);

    // T5: abort with termination during a transfer (R8)
    dmem[48] = mk_hdr(29, 0, 1'b1, 1'b0, 3'b000);
    push_inline(48, 0, 29, 1'b1);
    w0 = wb_cnt; r0 = rx_cnt;
    term_active = 1'b1;
    kick(48);
    do begin @(posedge clk); end while (rx_cnt - r0 < 4);
    #1 abort_in = 5'b00001;
    @(posedge clk); #1 abort_in = 5'b0;
    wait_wb(w0);
    begin
      int got;
      got = rx_cnt - r0;
      chk(got < 30 && got >= 4, "R8 stream cut short", 64'(got), 64'd5);
      chk(wb_data == mk_stat(5'b00001, got), "R8 status counts accepted bytes", wb_data, mk_stat(5'b00001, got));
      repeat (10) @(posedge clk);
      chk(rx_cnt - r0 == got, "R8 no byte after termination", 64'(rx_cnt - r0), 64'(got));
      chk(!busy && !out_valid, "R8 idle after write-back", {62'b0, busy, out_valid}, 64'b0);
    end
    exp_q.delete();
    term_active = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule